// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This block is the digital decision logic of a battery-charger protection stage. It watches six synchronous comparator flags: supply valid, input over-voltage, output over-current, battery over-voltage, over-temperature and reverse-voltage lockout. From them it decides when the main input pass switch may conduct and when the secondary pass transistor may follow its external gate control. Each fault class has its own qualification delay and its own recovery delay. Over-current and battery over-voltage trips are counted, and once either count reaches its limit the switch stays off until the supply is removed and restored.

All delays are given in microseconds and converted to clock cycles from a clock-frequency parameter. Dropping the supply-valid flag acts as an asynchronous reset for the whole block. Two status outputs are provided. One reports the permanent latch-off. The other holds a code for the cause of the most recent trip.

Top module: `chg_guard_seq`

## Requirements
- R1: After `por_ok` rises, `main_sw_en` stays low for exactly POR cycles and may go high after the POR-th rising clock edge, where POR is the cycle count of the 8000 us power-on blanking.
- R2: While `ovp_flag` is high, `main_sw_en` is low in the same cycle, with no clock edge needed.
- R3: After `ovp_flag` clears, `main_sw_en` returns only after 8000 us worth of consecutive edges that sample the flag low. A re-assertion during that window restarts the full window.
- R4: `ocp_flag` trips the switch only after it has been sampled high on 176 us worth of consecutive edges. A shorter pulse has no effect on the switch and is not counted.
- R5: An over-current trip holds `main_sw_en` low for 64000 us worth of edges counted from the trip edge, whatever the flag does in that time.
- R6: `bovp_flag` trips the switch after 176 us worth of consecutive high samples. The switch returns on the first edge that samples the flag low.
- R7: Over-current and battery over-voltage trips are counted separately. On the 16th trip of either kind, `latched_off` goes high and `main_sw_en` stays low until `por_ok` falls. A total of 15 trips of one kind does not latch.
- R8: While `otp_flag` is high, `main_sw_en` is low in the same cycle. It returns when the flag clears, with no added delay.
- R9: `aux_pass_en` equals `gate_ctl` except that it is forced low in three cases: while `rvl_flag` is high, while an input over-voltage, over-current or battery over-voltage fault is tripped or recovering, and while `por_ok` is low.
- R10: `por_ok` low clears everything at once without a clock edge. Both enables go low, `latched_off` goes low and `last_cause` becomes 0, and all timers and counters restart.
- R11: `last_cause` updates on the clock edge of a trip. The codes are 0 none, 1 input over-voltage, 2 over-current, 3 battery over-voltage and 4 over-temperature (on its rising edge). When trips occur on the same edge, the priority is 1, then 2, then 3, then 4.
- R12: A delay of `us` microseconds takes ceil(us * CLK_HZ / 1e6) cycles. For example, 176 us at 50 kHz takes 9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_ok | input | 1 | Supply valid; low acts as an asynchronous clear |
| ovp_flag | input | 1 | Input over-voltage comparator |
| ocp_flag | input | 1 | Output over-current comparator |
| bovp_flag | input | 1 | Battery over-voltage comparator |
| otp_flag | input | 1 | Over-temperature comparator |
| rvl_flag | input | 1 | Reverse-voltage lockout comparator |
| gate_ctl | input | 1 | External gate request for the secondary transistor |
| main_sw_en | output | 1 | Main pass switch enable |
| aux_pass_en | output | 1 | Secondary pass transistor enable |
| latched_off | output | 1 | Permanent latch-off after 16 counted trips |
| last_cause | output | 3 | Code of the most recent trip |

## Verification
The bench samples the enables exactly one edge before and one edge after each blanking and recovery boundary. A window that is off by one cycle, or a recovery that counts from the wrong event, therefore shows up as an enable in the wrong state. Random glitches shorter than the blanking length are sent on the over-current and battery lines; a design that kept partial counts or counted them as trips would latch before the 16th real trip or block the switch. Exactly 15 over-current trips are issued before the 16th, and a battery trip is mixed in, so a shared counter or an off-by-one limit latches early. Simultaneous input over-voltage and over-temperature onsets check the cause priority.

// File: rtl/chg_guard_pkg.sv
`timescale 1ns/1ps
package chg_guard_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_OVP  = 3'd1,
    CAUSE_OCP  = 3'd2,
    CAUSE_BOVP = 3'd3,
    CAUSE_OTP  = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_BLANK = 2'd1,
    CH_TRIP  = 2'd2,
    CH_RECOV = 2'd3
  } chan_st_e;

  localparam int CH_OVP  = 0;
  localparam int CH_OCP  = 1;
  localparam int CH_BOVP = 2;
  localparam int N_CH    = 3;

  // Delay in microseconds to clock cycles, rounded up.
  function automatic int us_to_cyc(longint clk_hz, longint us);
    longint prod;
    prod = us * clk_hz;
    return int'((prod + 999_999) / 1_000_000);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chg_por_blank.sv
`timescale 1ns/1ps
module chg_por_blank #(
  parameter int CYC = 400
)(
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CW = $clog2(CYC + 2);
  localparam logic [CW-1:0] LAST = (CYC > 1) ? CW'(CYC - 1) : '0;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == LAST) ready <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

endmodule

// File: rtl/chg_fault_chan.sv
`timescale 1ns/1ps
module chg_fault_chan import chg_guard_pkg::*; #(
  parameter int BLANK_CYC  = 9,
  parameter int REC_CYC    = 0,
  parameter bit WAIT_CLEAR = 1'b1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  output logic active,
  output logic trip
);
  localparam int CW = $clog2(max2(BLANK_CYC, REC_CYC) + 2);
  localparam logic [CW-1:0] BLAST = (BLANK_CYC > 1) ? CW'(BLANK_CYC - 1) : '0;
  localparam logic [CW-1:0] RLAST = (REC_CYC > 1) ? CW'(REC_CYC - 1) : '0;

  chan_st_e      st, nxt_st;
  logic [CW-1:0] cnt, nxt_cnt;

  always_comb begin
    nxt_st  = st;
    nxt_cnt = cnt;
    trip    = 1'b0;
    unique case (st)
      CH_IDLE: begin
        if (flag) begin
          if (BLANK_CYC <= 1) begin
            trip    = 1'b1;
            nxt_st  = WAIT_CLEAR ? CH_TRIP : CH_RECOV;
            nxt_cnt = '0;
          end else begin
            nxt_st  = CH_BLANK;
            nxt_cnt = CW'(1);
          end
        end
      end
      CH_BLANK: begin
        if (!flag) begin
          nxt_st  = CH_IDLE;
          nxt_cnt = '0;
        end else if (cnt == BLAST) begin
          trip    = 1'b1;
          nxt_st  = WAIT_CLEAR ? CH_TRIP : CH_RECOV;
          nxt_cnt = '0;
        end else begin
          nxt_cnt = cnt + 1'b1;
        end
      end
      CH_TRIP: begin
        if (!flag) begin
          if (REC_CYC <= 1) begin
            nxt_st  = CH_IDLE;
            nxt_cnt = '0;
          end else begin
            nxt_st  = CH_RECOV;
            nxt_cnt = CW'(1);
          end
        end
      end
      CH_RECOV: begin
        if (WAIT_CLEAR && flag) begin
          nxt_st  = CH_TRIP;
          nxt_cnt = '0;
        end else if (cnt == RLAST) begin
          nxt_st  = CH_IDLE;
          nxt_cnt = '0;
        end else begin
          nxt_cnt = cnt + 1'b1;
        end
      end
      default: begin
        nxt_st  = CH_IDLE;
        nxt_cnt = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= CH_IDLE;
      cnt <= '0;
    end else begin
      st  <= nxt_st;
      cnt <= nxt_cnt;
    end
  end

  assign active = (st == CH_TRIP) || (st == CH_RECOV) ||
                  ((BLANK_CYC == 0) && flag && (st == CH_IDLE));

  // Length of the current run of high samples, kept for the check below.
  if (BLANK_CYC >= 2) begin : g_blank_chk
    localparam int HW = $clog2(BLANK_CYC + 1);
    localparam logic [HW-1:0] HMAX = HW'(BLANK_CYC);
    logic [HW-1:0] hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hi_run <= '0;
      else if (!flag)          hi_run <= '0;
      else if (hi_run != HMAX) hi_run <= hi_run + 1'b1;
    end
    // R4
    blank_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip |-> (flag && (hi_run >= HW'(BLANK_CYC - 1))));
  end

  // R3
  trip_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> flag);

endmodule

// File: rtl/chg_evt_cnt.sv
`timescale 1ns/1ps
module chg_evt_cnt #(
  parameter int LIMIT = 16
)(
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = (LIMIT > 1) ? CW'(LIMIT - 1) : '0;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else if (ev && !hit) begin
      if (cnt == LAST) hit <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R7
  hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> hit);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/chg_guard_seq.sv
`timescale 1ns/1ps
module chg_guard_seq import chg_guard_pkg::*; #(
  parameter longint CLK_HZ        = 10_000_000,
  parameter int     POR_BLANK_US  = 8000,
  parameter int     OVP_REC_US    = 8000,
  parameter int     OCP_BLANK_US  = 176,
  parameter int     OCP_REC_US    = 64000,
  parameter int     BOVP_BLANK_US = 176,
  parameter int     BOVP_REC_US   = 0,
  parameter int     EVT_LIMIT     = 16
)(
  input  logic       clk,
  input  logic       por_ok,
  input  logic       ovp_flag,
  input  logic       ocp_flag,
  input  logic       bovp_flag,
  input  logic       otp_flag,
  input  logic       rvl_flag,
  input  logic       gate_ctl,
  output logic       main_sw_en,
  output logic       aux_pass_en,
  output logic       latched_off,
  output logic [2:0] last_cause
);
  localparam int POR_CYC = us_to_cyc(CLK_HZ, POR_BLANK_US);

  logic            por_ready;
  logic [N_CH-1:0] flag_v, act_v, trip_v, hit_v;
  logic            any_fault;
  logic            otp_q;
  cause_e          cause_q;

  assign flag_v = {bovp_flag, ocp_flag, ovp_flag};

  chg_por_blank #(.CYC(POR_CYC)) u_por (
    .clk   (clk),
    .rst_n (por_ok),
    .ready (por_ready)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int BUS = (g == CH_OVP) ? 0 :
                         (g == CH_OCP) ? OCP_BLANK_US : BOVP_BLANK_US;
    localparam int RUS = (g == CH_OVP) ? OVP_REC_US :
                         (g == CH_OCP) ? OCP_REC_US : BOVP_REC_US;
    localparam bit WC  = (g != CH_OCP);

    chg_fault_chan #(
      .BLANK_CYC  (us_to_cyc(CLK_HZ, BUS)),
      .REC_CYC    (us_to_cyc(CLK_HZ, RUS)),
      .WAIT_CLEAR (WC)
    ) u_chan (
      .clk    (clk),
      .rst_n  (por_ok),
      .flag   (flag_v[g]),
      .active (act_v[g]),
      .trip   (trip_v[g])
    );

    if (g == CH_OVP) begin : g_nocnt
      assign hit_v[g] = 1'b0;
    end else begin : g_cnt
      chg_evt_cnt #(.LIMIT(EVT_LIMIT)) u_cnt (
        .clk   (clk),
        .rst_n (por_ok),
        .ev    (trip_v[g]),
        .hit   (hit_v[g])
      );
    end
  end

  assign any_fault   = |act_v;
  assign latched_off = |hit_v;
  assign main_sw_en  = por_ok && por_ready && !latched_off && !any_fault && !otp_flag;
  assign aux_pass_en = por_ok && gate_ctl && !rvl_flag && !any_fault;

  always_ff @(posedge clk or negedge por_ok) begin
    if (!por_ok) begin
      otp_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      otp_q <= otp_flag;
      if (trip_v[CH_OVP])            cause_q <= CAUSE_OVP;
      else if (trip_v[CH_OCP])       cause_q <= CAUSE_OCP;
      else if (trip_v[CH_BOVP])      cause_q <= CAUSE_BOVP;
      else if (otp_flag && !otp_q)   cause_q <= CAUSE_OTP;
    end
  end

  assign last_cause = cause_q;

  // R1
  por_gate_chk: assert property (@(posedge clk) disable iff (!por_ok)
    main_sw_en |-> por_ready);

  // R2
  ovp_off_chk: assert property (@(posedge clk) disable iff (!por_ok)
    ovp_flag |-> !main_sw_en);

  // R8
  otp_off_chk: assert property (@(posedge clk) disable iff (!por_ok)
    otp_flag |-> !main_sw_en);

  // R9
  aux_block_chk: assert property (@(posedge clk) disable iff (!por_ok)
    (rvl_flag || ovp_flag) |-> !aux_pass_en);

  // R7
  latch_off_chk: assert property (@(posedge clk) disable iff (!por_ok)
    latched_off |-> !main_sw_en);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!por_ok)
    latched_off |=> latched_off);

  // R11
  cause_code_chk: assert property (@(posedge clk) disable iff (!por_ok)
    last_cause <= 3'd4);

endmodule

// File: tb/chg_guard_seq_tb.sv
`timescale 1ns/1ps
module chg_guard_seq_tb;

  localparam longint CLK_HZ = 50_000;

  // R12: bench-side conversion with integer ceiling done by remainder test
  function automatic int cyc_of(longint us);
    longint q;
    q = (us * CLK_HZ) / 1_000_000;
    if (q * 1_000_000 < us * CLK_HZ) q = q + 1;
    return int'(q);
  endfunction

  function automatic logic exp_aux(logic gate, logic rvl, logic flt);
    return gate & ~rvl & ~flt;
  endfunction

  localparam int POR_N   = 400;
  localparam int OVP_REC = 400;
  localparam int OCP_B   = 9;
  localparam int OCP_REC = 3200;
  localparam int BOV_B   = 9;

  logic clk = 1'b0;
  logic por_ok = 1'b0, ovp_flag = 1'b0, ocp_flag = 1'b0, bovp_flag = 1'b0;
  logic otp_flag = 1'b0, rvl_flag = 1'b0, gate_ctl = 1'b1;
  logic main_sw_en, aux_pass_en, latched_off;
  logic [2:0] last_cause;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cause = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chg_guard_seq #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .por_ok(por_ok), .ovp_flag(ovp_flag), .ocp_flag(ocp_flag),
    .bovp_flag(bovp_flag), .otp_flag(otp_flag), .rvl_flag(rvl_flag),
    .gate_ctl(gate_ctl), .main_sw_en(main_sw_en), .aux_pass_en(aux_pass_en),
    .latched_off(latched_off), .last_cause(last_cause)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic power_up();
    por_ok = 1'b1;
    tick(POR_N - 1);
    chk("R1 main off before blank end", main_sw_en, 0);
    tick(1);
    chk("R1 main on at blank end", main_sw_en, 1);
  endtask

  task automatic ocp_event();
    ocp_flag = 1'b1;
    tick(OCP_B);
    ocp_flag = 1'b0;
    tick(OCP_REC);
  endtask

  task automatic bovp_event();
    bovp_flag = 1'b1;
    tick(BOV_B);
    bovp_flag = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(3);
    // R10 reset state
    chk("R10 main reset", main_sw_en, 0);
    chk("R10 aux reset", aux_pass_en, 0);
    chk("R10 latch reset", latched_off, 0);
    chk("R11 cause reset", last_cause, 0);
    chk("R12 blank cycles", cyc_of(176), OCP_B);
    chk("R12 por cycles", cyc_of(8000), POR_N);

    power_up();
    chk("R9 aux follows gate", aux_pass_en, exp_aux(1, 0, 0));
    gate_ctl = 1'b0; #1;
    chk("R9 aux gate low", aux_pass_en, 0);
    gate_ctl = 1'b1; rvl_flag = 1'b1; #1;
    chk("R9 aux rvl", aux_pass_en, 0);
    chk("R9 main unaffected by rvl", main_sw_en, 1);
    rvl_flag = 1'b0; #1;

    // R2 / R11: input over-voltage together with over-temperature onset
    ovp_flag = 1'b1; otp_flag = 1'b1; #1;
    chk("R2 ovp immediate off", main_sw_en, 0);
    chk("R9 aux off on ovp", aux_pass_en, 0);
    tick(1);
    chk("R11 ovp wins priority", last_cause, 1);
    tick(5);
    ovp_flag = 1'b0; otp_flag = 1'b0;
    tick(OVP_REC - 1);
    chk("R3 ovp recovery not done", main_sw_en, 0);
    tick(1);
    chk("R3 ovp recovery done", main_sw_en, 1);
    // R3 restart of the window
    ovp_flag = 1'b1; tick(5); ovp_flag = 1'b0;
    tick(100);
    ovp_flag = 1'b1; tick(1); ovp_flag = 1'b0;
    tick(OVP_REC - 1);
    chk("R3 restarted window not done", main_sw_en, 0);
    tick(1);
    chk("R3 restarted window done", main_sw_en, 1);
    exp_cause = 1;

    // R4 short over-current pulse
    ocp_flag = 1'b1;
    tick(OCP_B - 1);
    chk("R4 short ocp keeps on", main_sw_en, 1);
    ocp_flag = 1'b0;
    tick(1);
    chk("R4 short ocp no cause", last_cause, exp_cause);

    // R4 / R5 real trip (over-current trip 1)
    ocp_flag = 1'b1;
    tick(OCP_B - 1);
    chk("R4 ocp before blank end", main_sw_en, 1);
    tick(1);
    chk("R4 ocp trips", main_sw_en, 0);
    chk("R9 aux off during ocp", aux_pass_en, 0);
    chk("R11 cause ocp", last_cause, 2);
    tick(20);
    ocp_flag = 1'b0;
    tick(OCP_REC - 21);
    chk("R5 ocp recovery not done", main_sw_en, 0);
    tick(1);
    chk("R5 ocp recovery done", main_sw_en, 1);

    // R8 over-temperature
    otp_flag = 1'b1; #1;
    chk("R8 otp off", main_sw_en, 0);
    chk("R9 aux not forced by otp", aux_pass_en, 1);
    tick(1);
    chk("R11 cause otp", last_cause, 4);
    otp_flag = 1'b0; #1;
    chk("R8 otp clears", main_sw_en, 1);
    exp_cause = 4;

    // R6 battery over-voltage (battery trip 1)
    bovp_flag = 1'b1;
    tick(BOV_B - 1);
    chk("R6 bovp before blank end", main_sw_en, 1);
    tick(1);
    chk("R6 bovp trips", main_sw_en, 0);
    chk("R11 cause bovp", last_cause, 3);
    tick(20);
    chk("R6 bovp held off", main_sw_en, 0);
    bovp_flag = 1'b0;
    tick(1);
    chk("R6 bovp returns", main_sw_en, 1);
    exp_cause = 3;

    // Random phase: glitches under the blanking length and side inputs
    void'($urandom(32'd4242));
    for (int i = 0; i < 150; i++) begin
      int kind;
      int len;
      kind = int'($urandom % 4);
      case (kind)
        0: begin
          len = 1 + int'($urandom % (OCP_B - 1));
          ocp_flag = 1'b1;
          for (int k = 0; k < len; k++) begin
            tick(1);
            chk("R4 ocp glitch ignored", main_sw_en, 1);
          end
          ocp_flag = 1'b0; tick(1);
        end
        1: begin
          len = 1 + int'($urandom % (BOV_B - 1));
          bovp_flag = 1'b1;
          for (int k = 0; k < len; k++) begin
            tick(1);
            chk("R6 bovp glitch ignored", main_sw_en, 1);
          end
          bovp_flag = 1'b0; tick(1);
        end
        2: begin
          gate_ctl = 1'($urandom % 2);
          rvl_flag = 1'($urandom % 2);
          #1;
          chk("R9 aux random", aux_pass_en, exp_aux(gate_ctl, rvl_flag, 0));
          tick(1);
        end
        default: begin
          len = 1 + int'($urandom % 5);
          otp_flag = 1'b1;
          tick(len);
          chk("R8 otp random off", main_sw_en, 0);
          exp_cause = 4;
          otp_flag = 1'b0; #1;
          chk("R8 otp random on", main_sw_en, 1);
          tick(1);
        end
      endcase
    end
    gate_ctl = 1'b1; rvl_flag = 1'b0;
    tick(1);
    chk("R11 cause after random", last_cause, exp_cause);
    chk("R4 glitches did not latch", latched_off, 0);

    // R7 over-current trips 2..15, then the 16th
    for (int e = 2; e <= 15; e++) ocp_event();
    chk("R7 fifteen trips no latch", latched_off, 0);
    chk("R7 main on after fifteen", main_sw_en, 1);
    ocp_flag = 1'b1;
    tick(OCP_B);
    ocp_flag = 1'b0;
    chk("R7 sixteenth trip latches", latched_off, 1);
    tick(OCP_REC + 10);
    chk("R7 latched stays off", main_sw_en, 0);
    chk("R7 latch held", latched_off, 1);

    // R10 asynchronous clear
    por_ok = 1'b0; #1;
    chk("R10 latch cleared", latched_off, 0);
    chk("R10 main cleared", main_sw_en, 0);
    chk("R10 aux cleared", aux_pass_en, 0);
    chk("R10 cause cleared", last_cause, 0);
    tick(2);
    power_up();
    chk("R10 restart unlatched", latched_off, 0);

    // R7 battery counter on its own
    for (int e = 1; e <= 15; e++) bovp_event();
    chk("R7 fifteen bovp no latch", latched_off, 0);
    chk("R7 main on after bovp fifteen", main_sw_en, 1);
    bovp_flag = 1'b1;
    tick(BOV_B);
    chk("R7 bovp sixteenth latches", latched_off, 1);
    bovp_flag = 1'b0;
    tick(5);
    chk("R7 bovp latched off", main_sw_en, 0);
    chk("R11 cause bovp latch", last_cause, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(190_000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule